// File: doc/BRIEF.md
# Banked UART Host Register Decoder

This block sits between a byte-wide host bus and the rest of a 16550-style serial port. Each host access carries a 3-bit address, a read strobe, a write strobe and an active-low select level. The block maps that access onto one of two register banks. Bit 7 of the line-control register chooses the bank. Several addresses lead to different places on a read and on a write. For example, address 0 reads the receive FIFO and writes the transmit FIFO. Address 2 reads interrupt identification and writes FIFO control.

The block holds the writable control registers and drives their values to the neighbouring logic. It returns read data as a combinational function of the current access. It gives the FIFOs a one-cycle pop strobe or push strobe for each host access, however many cycles the host strobe stays high. The FIFOs, the baud generator, the interrupt prioritiser and the modem-line logic all sit outside. Receive data, interrupt state, line status and modem status come in on ports.

Top module: `uart_host_regs`

## Requirements
- R1: After reset every writable register output is zero. A read of address 2 with `int_pend` low and `int_id` zero returns 0x01.
- R2: While `sel_n` is 1, no register changes, `rdata` is zero and neither `rx_pop` nor `tx_push` pulses.
- R3: With bank bit 0, a read of address 0 returns `rx_data` and raises `rx_pop` for exactly one cycle per access, even if `rd` stays high for several cycles.
- R4: With bank bit 0, a write to address 0 raises `tx_push` for exactly one cycle and changes no register.
- R5: With bank bit 0, addresses 1, 4 and 7 read and write the interrupt-enable, modem-control and scratch registers.
- R6: In either bank, a write to address 2 loads FIFO control. A read of address 2 returns {fcr[0], fcr[0], 2'b00, int_id[2:0], ~int_pend}.
- R7: Address 3 reads and writes line control in either bank. Its bit 7 selects bank 1 from the cycle after the write.
- R8: In either bank, address 5 reads `lsr_in` and address 6 reads `msr_in`. Writes to these two addresses change no register.
- R9: With bank bit 1, addresses 0 and 1 read and write the divisor low and high bytes. Neither `rx_pop` nor `tx_push` fires.
- R10: With bank bit 1, address 4 reads and writes the extended divisor register and address 7 reads and writes the status/control register. Modem control and scratch keep their values.
- R11: `rdata` is zero whenever `rd` is low. A write strobe held high for several cycles stores only the data of its first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select; accesses count only while it is 0 |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data; also the byte pushed into the transmit FIFO |
| rdata | output | DATA_W | Read data, zero when no read is active |
| rx_data | input | DATA_W | Head byte of the receive FIFO |
| rx_pop | output | 1 | One-cycle pop strobe to the receive FIFO |
| tx_push | output | 1 | One-cycle push strobe to the transmit FIFO |
| int_pend | input | 1 | An interrupt is pending |
| int_id | input | 3 | Identifier of the pending interrupt source |
| lsr_in | input | DATA_W | Line status value |
| msr_in | input | DATA_W | Modem status value |
| ier | output | DATA_W | Interrupt-enable register |
| fcr | output | DATA_W | FIFO-control register |
| lcr | output | DATA_W | Line-control register (bit 7 = bank select) |
| mcr | output | DATA_W | Modem-control register |
| scr | output | DATA_W | Scratch register |
| dll | output | DATA_W | Divisor low byte |
| dlm | output | DATA_W | Divisor high byte |
| dlx | output | DATA_W | Extended divisor register |
| mcx | output | DATA_W | Status/control register |

## Verification
The bench builds the block with the default DATA_W of 8. With that width, the bank bit is the top bit of line control, and every field of the composed interrupt-identification byte can be compared bit for bit. A vector table walks each address in both banks and checks that the registers of one bank are untouched by writes to the other. Directed tests then cover held strobes, the first access after a bank switch, the deselected state, and writes aimed at the status addresses.

// File: rtl/uart_hreg_pkg.sv
package uart_hreg_pkg;

  localparam int NSLOT = 9;
  localparam int BANK_BIT = 7;

  typedef enum logic [3:0] {
    S_IER = 4'd0,
    S_FCR = 4'd1,
    S_LCR = 4'd2,
    S_MCR = 4'd3,
    S_SCR = 4'd4,
    S_DLL = 4'd5,
    S_DLM = 4'd6,
    S_DLX = 4'd7,
    S_MCX = 4'd8
  } slot_e;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_RBR  = 3'd1,
    RS_IIR  = 3'd2,
    RS_LSR  = 3'd3,
    RS_MSR  = 3'd4,
    RS_SLOT = 3'd5
  } rsrc_e;

  typedef struct packed {
    rsrc_e rsrc;
    slot_e rslot;
    logic  wen;
    slot_e wslot;
    logic  fifo_port;
  } map_t;

  function automatic map_t map_addr(input logic [2:0] a, input logic bank);
    map_t m;
    m.rsrc      = RS_SLOT;
    m.rslot     = S_IER;
    m.wen       = 1'b1;
    m.wslot     = S_IER;
    m.fifo_port = 1'b0;
    case (a)
      3'd0: begin
        if (bank) begin
          m.rslot = S_DLL;
          m.wslot = S_DLL;
        end else begin
          m.rsrc      = RS_RBR;
          m.wen       = 1'b0;
          m.fifo_port = 1'b1;
        end
      end
      3'd1: begin
        m.rslot = bank ? S_DLM : S_IER;
        m.wslot = bank ? S_DLM : S_IER;
      end
      3'd2: begin
        m.rsrc  = RS_IIR;
        m.wslot = S_FCR;
      end
      3'd3: begin
        m.rslot = S_LCR;
        m.wslot = S_LCR;
      end
      3'd4: begin
        m.rslot = bank ? S_DLX : S_MCR;
        m.wslot = bank ? S_DLX : S_MCR;
      end
      3'd5: begin
        m.rsrc = RS_LSR;
        m.wen  = 1'b0;
      end
      3'd6: begin
        m.rsrc = RS_MSR;
        m.wen  = 1'b0;
      end
      default: begin
        m.rslot = bank ? S_MCX : S_SCR;
        m.wslot = bank ? S_MCX : S_SCR;
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/uart_hreg_edge.sv
module uart_hreg_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] first
);

  logic [N-1:0] lvl_q;
  logic [N-1:0] lvl_d;

  always_comb begin
    lvl_d = lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl_d[i];
    end
    assign first[i] = lvl[i] & ~lvl_q[i];

    // R11
    first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first[i] |=> !first[i]);
  end

endmodule

// File: rtl/uart_hreg_decode.sv
module uart_hreg_decode
  import uart_hreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             bank,
  input  logic             rd_act,
  input  logic             rd_first,
  input  logic             wr_first,
  output rsrc_e            rsrc,
  output slot_e            rslot,
  output logic [NSLOT-1:0] we,
  output logic             pop,
  output logic             push
);

  map_t m;

  always_comb begin
    m = map_addr(addr, bank);
  end

  always_comb begin
    rsrc  = rd_act ? m.rsrc : RS_NONE;
    rslot = m.rslot;
    pop   = rd_first & m.fifo_port;
    push  = wr_first & m.fifo_port;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_we
    assign we[i] = wr_first & m.wen & (m.wslot == slot_e'(i));
  end

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  // R4
  push_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (we == '0));

endmodule

// File: rtl/uart_hreg_bank.sv
module uart_hreg_bank #(
  parameter int DATA_W = 8,
  parameter int NREG   = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREG-1:0]             we,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NREG-1:0][DATA_W-1:0] q
);

  logic [NREG-1:0][DATA_W-1:0] q_d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_comb begin
      q_d[i] = q[i];
      if (we[i]) q_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= '0;
      else if (we[i]) q[i] <= q_d[i];
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(q[i]));
  end

endmodule

// File: rtl/uart_hreg_rdmux.sv
module uart_hreg_rdmux
  import uart_hreg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rsrc_e                        rsrc,
  input  slot_e                        rslot,
  input  logic [NSLOT-1:0][DATA_W-1:0] q,
  input  logic [DATA_W-1:0]            rx_data,
  input  logic [DATA_W-1:0]            iir,
  input  logic [DATA_W-1:0]            lsr_in,
  input  logic [DATA_W-1:0]            msr_in,
  output logic [DATA_W-1:0]            rdata
);

  always_comb begin
    case (rsrc)
      RS_RBR:  rdata = rx_data;
      RS_IIR:  rdata = iir;
      RS_LSR:  rdata = lsr_in;
      RS_MSR:  rdata = msr_in;
      RS_SLOT: rdata = q[rslot];
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_hreg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [2:0]        addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_pop,
  output logic              tx_push,
  input  logic              int_pend,
  input  logic [2:0]        int_id,
  input  logic [DATA_W-1:0] lsr_in,
  input  logic [DATA_W-1:0] msr_in,
  output logic [DATA_W-1:0] ier,
  output logic [DATA_W-1:0] fcr,
  output logic [DATA_W-1:0] lcr,
  output logic [DATA_W-1:0] mcr,
  output logic [DATA_W-1:0] scr,
  output logic [DATA_W-1:0] dll,
  output logic [DATA_W-1:0] dlm,
  output logic [DATA_W-1:0] dlx,
  output logic [DATA_W-1:0] mcx
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]       rst_pipe;
  logic                         rst_q_n;
  logic                         rd_act;
  logic                         wr_act;
  logic [1:0]                   firsts;
  rsrc_e                        rsrc;
  slot_e                        rslot;
  logic [NSLOT-1:0]             we;
  logic [NSLOT-1:0][DATA_W-1:0] q;
  logic [DATA_W-1:0]            iir;
  logic                         bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  always_comb begin
    rd_act = rd & ~sel_n;
    wr_act = wr & ~sel_n;
    bank   = q[S_LCR][BANK_BIT];
    iir    = DATA_W'({q[S_FCR][0], q[S_FCR][0], 2'b00, int_id, ~int_pend});
  end

  uart_hreg_edge #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_q_n),
    .lvl   ({rd_act, wr_act}),
    .first (firsts)
  );

  uart_hreg_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .addr     (addr),
    .bank     (bank),
    .rd_act   (rd_act),
    .rd_first (firsts[1]),
    .wr_first (firsts[0]),
    .rsrc     (rsrc),
    .rslot    (rslot),
    .we       (we),
    .pop      (rx_pop),
    .push     (tx_push)
  );

  uart_hreg_bank #(.DATA_W(DATA_W), .NREG(NSLOT)) u_bank (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (we),
    .wdata (wdata),
    .q     (q)
  );

  uart_hreg_rdmux #(.DATA_W(DATA_W)) u_rd (
    .rsrc    (rsrc),
    .rslot   (rslot),
    .q       (q),
    .rx_data (rx_data),
    .iir     (iir),
    .lsr_in  (lsr_in),
    .msr_in  (msr_in),
    .rdata   (rdata)
  );

  assign ier = q[S_IER];
  assign fcr = q[S_FCR];
  assign lcr = q[S_LCR];
  assign mcr = q[S_MCR];
  assign scr = q[S_SCR];
  assign dll = q[S_DLL];
  assign dlm = q[S_DLM];
  assign dlx = q[S_DLX];
  assign mcx = q[S_MCX];

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    sel_n |-> (!rx_pop && !tx_push && rdata == '0));

  // R3
  pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_pop |=> !rx_pop);

  // R9
  pop_bank0_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_pop |-> !lcr[BANK_BIT]);

  // R9
  push_bank0_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    tx_push |-> !lcr[BANK_BIT]);

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd |-> rdata == '0);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(rx_pop && tx_push));

endmodule

// File: tb/tb_uart_host_regs.sv
`timescale 1ns/1ps
module tb_uart_host_regs;

  localparam int DW = 8;
  localparam int NV = 26;
  localparam int WATCHDOG = 20000;

  logic          clk;
  logic          rst_n;
  logic          sel_n;
  logic [2:0]    addr;
  logic          rd;
  logic          wr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [DW-1:0] rx_data;
  logic          rx_pop;
  logic          tx_push;
  logic          int_pend;
  logic [2:0]    int_id;
  logic [DW-1:0] lsr_in;
  logic [DW-1:0] msr_in;
  logic [DW-1:0] ier, fcr, lcr, mcr, scr, dll, dlm, dlx, mcx;

  int checks;
  int errors;
  bit done;

  uart_host_regs #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_pop(rx_pop),
    .tx_push(tx_push), .int_pend(int_pend), .int_id(int_id),
    .lsr_in(lsr_in), .msr_in(msr_in), .ier(ier), .fcr(fcr), .lcr(lcr),
    .mcr(mcr), .scr(scr), .dll(dll), .dlm(dlm), .dlx(dlx), .mcx(mcx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {req[3:0], op (1 = read), addr[2:0], data[7:0], expected[7:0]}
  localparam logic [23:0] VEC [NV] = '{
    {4'd5,  1'b0, 3'd1, 8'h0F, 8'h00},  // R5 write IER
    {4'd5,  1'b0, 3'd4, 8'h13, 8'h00},  // R5 write MCR
    {4'd5,  1'b0, 3'd7, 8'hA5, 8'h00},  // R5 write scratch
    {4'd5,  1'b1, 3'd1, 8'h00, 8'h0F},
    {4'd5,  1'b1, 3'd4, 8'h00, 8'h13},
    {4'd5,  1'b1, 3'd7, 8'h00, 8'hA5},
    {4'd6,  1'b0, 3'd2, 8'h01, 8'h00},  // R6 FIFO enable
    {4'd6,  1'b1, 3'd2, 8'h00, 8'hC1},
    {4'd7,  1'b0, 3'd3, 8'h83, 8'h00},  // R7 enter bank 1
    {4'd9,  1'b0, 3'd0, 8'h34, 8'h00},  // R9 divisor low
    {4'd9,  1'b0, 3'd1, 8'h12, 8'h00},  // R9 divisor high
    {4'd10, 1'b0, 3'd4, 8'h77, 8'h00},  // R10 extended divisor
    {4'd10, 1'b0, 3'd7, 8'h99, 8'h00},  // R10 status/control
    {4'd9,  1'b1, 3'd0, 8'h00, 8'h34},
    {4'd9,  1'b1, 3'd1, 8'h00, 8'h12},
    {4'd10, 1'b1, 3'd4, 8'h00, 8'h77},
    {4'd10, 1'b1, 3'd7, 8'h00, 8'h99},
    {4'd7,  1'b1, 3'd3, 8'h00, 8'h83},
    {4'd6,  1'b1, 3'd2, 8'h00, 8'hC1},
    {4'd8,  1'b1, 3'd5, 8'h00, 8'h60},
    {4'd7,  1'b0, 3'd3, 8'h03, 8'h00},  // R7 back to bank 0
    {4'd10, 1'b1, 3'd1, 8'h00, 8'h0F},
    {4'd10, 1'b1, 3'd4, 8'h00, 8'h13},
    {4'd10, 1'b1, 3'd7, 8'h00, 8'hA5},
    {4'd8,  1'b1, 3'd6, 8'h00, 8'hB0},
    {4'd7,  1'b1, 3'd3, 8'h00, 8'h03}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_op(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_op(input logic [2:0] a, output logic [DW-1:0] d, output logic p);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    d = rdata; p = rx_pop;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [71:0] regs_now();
    return {ier, fcr, lcr, mcr, scr, dll, dlm, dlx, mcx};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic p;
    logic [71:0] snap;
    int pops;
    int pushes;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; sel_n = 1'b0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    rx_data = 8'h5A; int_pend = 1'b0; int_id = 3'd0;
    lsr_in = 8'h60; msr_in = 8'hB0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(regs_now() == '0, "R1", "registers after reset", 32'(regs_now() != '0), 0);
    rd_op(3'd2, d, p);
    check(d == 8'h01, "R1", "IIR after reset", d, 8'h01);

    // R11 idle read data
    #1;
    check(rdata == 8'h00, "R11", "rdata with rd low", rdata, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[23:20]);
      if (v[19]) begin
        rd_op(v[18:16], d, p);
        check(d == v[7:0], rq, $sformatf("vector %0d read", i), d, v[7:0]);
      end else begin
        wr_op(v[18:16], v[15:8]);
      end
    end

    // R3 held read: one pop, data from receive FIFO
    pops = 0;
    @(negedge clk);
    addr = 3'd0; rd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      if (rx_pop) pops++;
      if (k == 0) check(rdata == 8'h5A, "R3", "receive data", rdata, 8'h5A);
      @(negedge clk);
    end
    rd = 1'b0;
    check(pops == 1, "R3", "pops for held read", pops, 1);

    // R4 write to transmit holding: one push, registers untouched
    snap = regs_now();
    pushes = 0;
    @(negedge clk);
    addr = 3'd0; wdata = 8'hC3; wr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      if (tx_push) pushes++;
      @(negedge clk);
    end
    wr = 1'b0;
    check(pushes == 1, "R4", "pushes for held write", pushes, 1);
    check(regs_now() == snap, "R4", "registers after push", 32'(regs_now() != snap), 0);

    // R11 held write keeps first-cycle data
    @(negedge clk);
    addr = 3'd7; wdata = 8'h11; wr = 1'b1;
    @(negedge clk);
    wdata = 8'h22;
    @(negedge clk);
    wr = 1'b0;
    #1;
    check(scr == 8'h11, "R11", "scratch after held write", scr, 8'h11);

    // R2 deselected: write ignored, no read data, no pop
    @(negedge clk);
    sel_n = 1'b1; addr = 3'd7; wdata = 8'hEE; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 3'd0; rd = 1'b1;
    #1;
    check(rdata == 8'h00, "R2", "rdata deselected", rdata, 0);
    check(!rx_pop, "R2", "pop deselected", rx_pop, 0);
    @(negedge clk);
    rd = 1'b0; sel_n = 1'b0;
    #1;
    check(scr == 8'h11, "R2", "scratch after deselected write", scr, 8'h11);

    // R8 writes to status addresses are ignored
    snap = regs_now();
    wr_op(3'd5, 8'hFF);
    wr_op(3'd6, 8'hFF);
    #1;
    check(regs_now() == snap, "R8", "registers after status writes", 32'(regs_now() != snap), 0);

    // R6 interrupt identification follows pending inputs
    int_pend = 1'b1; int_id = 3'd3;
    rd_op(3'd2, d, p);
    check(d == 8'hC6, "R6", "IIR with pending source", d, 8'hC6);
    int_pend = 1'b0; int_id = 3'd0;

    // R7 bank switch takes effect on the very next cycle
    @(negedge clk);
    addr = 3'd3; wdata = 8'h80; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 3'd0; rd = 1'b1;
    #1;
    check(rdata == 8'h34, "R7", "divisor low right after switch", rdata, 8'h34);
    check(!rx_pop, "R9", "no pop in bank 1", rx_pop, 0);
    @(negedge clk);
    rd = 1'b0;

    // R9 no push in bank 1, divisor low updated
    pushes = 0;
    @(negedge clk);
    addr = 3'd0; wdata = 8'h56; wr = 1'b1;
    #1;
    if (tx_push) pushes++;
    @(negedge clk);
    wr = 1'b0;
    #1;
    check(pushes == 0, "R9", "pushes in bank 1", pushes, 0);
    check(dll == 8'h56, "R9", "divisor low written", dll, 8'h56);
    check(mcr == 8'h13 && scr == 8'h11, "R10", "bank 0 regs kept", {mcr, scr}, 16'h1311);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule